// File: doc/BRIEF.md
# Battery-Domain Real-Time Clock with Periodic Subsecond Alarm

The block keeps time in a battery-backed domain. A strobe arriving once per 32.768 kHz oscillator period feeds a divider that, while the clock is enabled, yields one tick every 128 strobes (256 Hz). Each tick advances an 8-bit fraction-of-a-second count, and every wrap of that count advances a 32-bit count of whole seconds. A separate 8-bit down-counter acts as a periodic alarm. Each time it expires it reloads itself from a programmable period register and latches a sticky flag, which can raise an interrupt.

A host reaches everything through a flat register port: address, write strobe, write data and combinational read data. Writes that would clash with a running clock are refused. Every accepted write is followed by a short busy window, during which further writes to the time and period registers are refused. A ready output warns the host when a tick is about to change the counters, so that it knows when a read is coherent. Only the battery power-up reset initialises the time-keeping state. The ordinary system reset clears only the write pipeline and the tick pipeline.

Top module: `bbrtc`

## Requirements
- R1: While the enable bit (control bit 0) is 1, the fraction count increases by one for every 128 oscillator strobes. While it is 0, the counts do not move and `rdy` stays high.
- R2: When a tick takes the fraction count from 0xFF to 0x00, the 32-bit seconds count increases by exactly one, carrying from the low half into the high half.
- R3: The register map is as follows. Address 0 holds control: bit 0 enable, bit 1 alarm enable, bit 2 interrupt enable, bit 3 alarm flag. Address 1 holds the fraction count in bits 7:0. Address 2 holds seconds bits 15:0 and address 3 holds seconds bits 31:16. Address 4 holds the alarm period in bits 7:0. Other addresses read 0, and any address can be read at any time.
- R4: Writes to addresses 1–3 take effect only while enable is 0 and `busy` is 0. Other such writes leave the register unchanged and do not start a busy window.
- R5: A write to address 4 takes effect only while `busy` is 0 and at least one of enable and alarm enable is 0. An accepted write loads both the period and the alarm down-counter.
- R6: On each tick, with enable and alarm enable both 1, the down-counter decrements. On a tick where it is already 0, it reloads from the period and sets the alarm flag. With period P, the flag therefore sets on the (P+1)th tick after loading.
- R7: Battery power-up (`por_n` low) sets the fraction, seconds, period and down-counter to all ones and clears the control bits. Asserting `rst_n` alone leaves all of these unchanged.
- R8: `rdy` is low for exactly four system cycles around every tick: the cycle before it, the tick cycle, and the two cycles after it. Consecutive low windows begin exactly 128 strobes apart.
- R9: Every accepted write, including any write to address 0, drives `busy` high for exactly 3 cycles following the write edge.
- R10: Writing a 1 to control bit 3 clears the alarm flag, unless an expiry occurs in the same cycle. `irq` is high exactly while the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Battery-domain power-up reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| osc_tick | input | 1 | One-cycle strobe per 32.768 kHz oscillator period |
| addr | input | 3 | Register address |
| we | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| rdy | output | 1 | High when the counters are coherent |
| busy | output | 1 | Write synchronisation in progress |
| irq | output | 1 | Alarm interrupt |

## Verification
Faults in the divider or the tick pipeline show up at `rdy` within one tick period, as a wrong window length or a wrong spacing. They also show up in the fraction count read back after a known number of windows. A lost carry stays invisible until a wrap, so the cascade is forced by preloading 0xFE and 0x0000FFFF. A down-counter that is off by one shifts the flag by a whole tick, and the flag is observed after tick P and after tick P+1. Interlock faults appear at once: a refused write either changes the read-back or raises `busy`.

// File: rtl/bbrtc.sv
module bbrtc #(
  parameter int PRESCALE = 128,
  parameter int SUB_W    = 8,
  parameter int DW       = 16,
  parameter int AW       = 3,
  parameter int BUSY_CYC = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdy,
  output logic          busy,
  output logic          irq
);
  localparam int PW    = $clog2(PRESCALE);
  localparam int BW    = $clog2(BUSY_CYC + 1);
  localparam int SEC_W = 2 * DW;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SUB  = AW'(1);
  localparam logic [AW-1:0] A_SLO  = AW'(2);
  localparam logic [AW-1:0] A_SHI  = AW'(3);
  localparam logic [AW-1:0] A_RLD  = AW'(4);

  logic [PW-1:0]    presc;
  logic [SUB_W-1:0] sub, rld, acnt;
  logic [SEC_W-1:0] sec;
  logic             rtce, ase, aie, alsf;
  logic             tick_q, tick_d1, tick_d2;
  logic [BW-1:0]    bcnt;

  wire wen       = we && rst_n;
  wire tick_soon = rtce && osc_tick && (presc == PW'(PRESCALE - 1));
  wire cnt_run   = tick_q && rtce;
  wire alm_run   = cnt_run && ase;
  wire wr_ctrl   = wen && addr == A_CTRL;
  wire cnt_ok    = wen && !rtce && !busy;
  wire wr_sub    = cnt_ok && addr == A_SUB;
  wire wr_slo    = cnt_ok && addr == A_SLO;
  wire wr_shi    = cnt_ok && addr == A_SHI;
  wire wr_rld    = wen && addr == A_RLD && !busy && (!ase || !rtce);
  wire accepted  = wr_ctrl || wr_sub || wr_slo || wr_shi || wr_rld;
  wire expire    = alm_run && acnt == '0;

  assign busy = bcnt != '0;
  assign rdy  = !(tick_soon || tick_q || tick_d1 || tick_d2);
  assign irq  = alsf && aie;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DW'({alsf, aie, ase, rtce});
      A_SUB:   rdata = DW'(sub);
      A_SLO:   rdata = sec[DW-1:0];
      A_SHI:   rdata = sec[SEC_W-1:DW];
      A_RLD:   rdata = DW'(rld);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      presc <= '0;
      sub   <= '1;
      sec   <= '1;
      rld   <= '1;
      acnt  <= '1;
      rtce  <= 1'b0;
      ase   <= 1'b0;
      aie   <= 1'b0;
      alsf  <= 1'b0;
    end else begin
      if (!rtce)         presc <= '0;
      else if (osc_tick) presc <= tick_soon ? '0 : presc + 1'b1;

      if (cnt_run) begin
        sub <= sub + 1'b1;
        if (&sub) sec <= sec + 1'b1;
      end else begin
        if (wr_sub) sub <= wdata[SUB_W-1:0];
        if (wr_slo) sec[DW-1:0] <= wdata;
        if (wr_shi) sec[SEC_W-1:DW] <= wdata;
      end

      if (alm_run)     acnt <= (acnt == '0) ? rld : acnt - 1'b1;
      else if (wr_rld) acnt <= wdata[SUB_W-1:0];
      if (wr_rld)      rld  <= wdata[SUB_W-1:0];

      if (wr_ctrl) begin
        rtce <= wdata[0];
        ase  <= wdata[1];
        aie  <= wdata[2];
      end
      if (expire)                    alsf <= 1'b1;
      else if (wr_ctrl && wdata[3])  alsf <= 1'b0;
    end
  end

  wire sys_clr_n = rst_n && por_n;

  always_ff @(posedge clk or negedge sys_clr_n) begin
    if (!sys_clr_n) begin
      tick_q  <= 1'b0;
      tick_d1 <= 1'b0;
      tick_d2 <= 1'b0;
      bcnt    <= '0;
    end else begin
      tick_q  <= tick_soon;
      tick_d1 <= tick_q;
      tick_d2 <= tick_d1;
      if (accepted)   bcnt <= BW'(BUSY_CYC);
      else if (busy)  bcnt <= bcnt - 1'b1;
    end
  end

  p_carry_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    cnt_run && (&sub) |=> sec == $past(sec) + SEC_W'(1));
  p_locked_sub_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    we && addr == A_SUB && (rtce || busy) && !cnt_run |=> $stable(sub));
  p_flag_on_reload_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    alm_run && acnt == '0 |=> alsf);
  p_sysrst_keeps_r7: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> $stable(sec) && $stable(sub) && $stable(rld));
  p_rdy_after_tick_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    tick_q |=> !rdy);
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(busy) |=> busy);
endmodule

// File: tb/sim_bbrtc.sv
module sim_bbrtc;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rdy, busy, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bbrtc u0 (.clk(clk), .por_n(por_n), .rst_n(rst_n), .osc_tick(osc_tick),
            .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
            .rdy(rdy), .busy(busy), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      while (rdy) @(negedge clk);
      while (!rdy) @(negedge clk);
    end
  endtask

  task automatic t_por;
    logic [15:0] v;
    rd(3'd1, v); chk("R7 sub after por", v, 16'h00FF);
    rd(3'd2, v); chk("R7 sec lo after por", v, 16'hFFFF);
    rd(3'd3, v); chk("R7 sec hi after por", v, 16'hFFFF);
    rd(3'd4, v); chk("R7 period after por", v, 16'h00FF);
    rd(3'd0, v); chk("R7 ctrl after por", v, 16'h0000);
    rd(3'd6, v); chk("R3 unmapped reads 0", v, 16'h0000);
    chk("R8 rdy idle", rdy, 1'b1);
    chk("R10 irq idle", irq, 1'b0);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    @(negedge clk); addr = 3'd1; wdata = 16'h00FC; we = 1'b1;
    @(negedge clk); wdata = 16'h0011;
    chk("R9 busy cycle 1", busy, 1'b1);
    @(negedge clk); we = 1'b0;
    chk("R9 busy cycle 2", busy, 1'b1);
    @(negedge clk); chk("R9 busy cycle 3", busy, 1'b1);
    @(negedge clk); chk("R9 busy ends", busy, 1'b0);
    rd(3'd1, v); chk("R4 write during busy ignored", v, 16'h00FC);
  endtask

  task automatic t_gate;
    logic [15:0] v;
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0012);
    rd(3'd2, v); chk("R4 sec lo written", v, 16'hFFFF);
    rd(3'd3, v); chk("R4 sec hi written", v, 16'h0012);
    wr(3'd0, 16'h0001);
    @(negedge clk); addr = 3'd1; wdata = 16'h0033; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk("R4 refused write no busy", busy, 1'b0);
    rd(3'd1, v); chk("R4 write while enabled ignored", v, 16'h00FC);
    wr(3'd4, 16'h0007);
    rd(3'd4, v); chk("R5 period write with alarm off", v, 16'h0007);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_cascade;
    logic [15:0] v;
    wr(3'd1, 16'h00FE);
    wr(3'd0, 16'h0001);
    wait_ticks(1);
    rd(3'd1, v); chk("R1 one tick", v, 16'h00FF);
    rd(3'd2, v); chk("R2 no carry before wrap", v, 16'hFFFF);
    wait_ticks(1);
    rd(3'd1, v); chk("R2 sub wraps", v, 16'h0000);
    rd(3'd2, v); chk("R2 sec lo carries", v, 16'h0000);
    rd(3'd3, v); chk("R2 sec hi carries", v, 16'h0013);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_rdy;
    logic [15:0] v;
    int low, per;
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'h0001);
    while (rdy) @(negedge clk);
    low = 0; per = 0;
    while (!rdy) begin low++; per++; @(negedge clk); end
    chk("R8 low window 4 cycles", 16'(low), 16'd4);
    while (rdy) begin per++; @(negedge clk); end
    chk("R8 R1 tick spacing 128", 16'(per), 16'd128);
    while (!rdy) @(negedge clk);
    rd(3'd1, v); chk("R1 two ticks counted", v, 16'h0012);
    wr(3'd0, 16'h0000);
    per = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!rdy) per++; end
    chk("R1 no tick when disabled", 16'(per), 16'd0);
    rd(3'd1, v); chk("R1 frozen when disabled", v, 16'h0012);
  endtask

  task automatic t_alarm;
    logic [15:0] v;
    wr(3'd4, 16'h0002);
    wr(3'd0, 16'h0007);
    wait_ticks(2);
    rd(3'd0, v); chk("R6 no flag before P+1 ticks", v, 16'h0007);
    chk("R10 irq low", irq, 1'b0);
    wait_ticks(1);
    rd(3'd0, v); chk("R6 flag at P+1 ticks", v, 16'h000F);
    chk("R10 irq high", irq, 1'b1);
    wr(3'd0, 16'h000F);
    rd(3'd0, v); chk("R10 flag cleared", v, 16'h0007);
    chk("R10 irq cleared", irq, 1'b0);
    wr(3'd4, 16'h0009);
    rd(3'd4, v); chk("R5 period locked while running", v, 16'h0002);
    wait_ticks(2);
    chk("R6 no flag mid period", irq, 1'b0);
    wait_ticks(1);
    chk("R6 flag after reload period", irq, 1'b1);
    wr(3'd0, 16'h0003);
    chk("R10 irq masked", irq, 1'b0);
    rd(3'd0, v); chk("R10 flag kept when masked", v, 16'h000B);
    wr(3'd0, 16'h0008);
  endtask

  task automatic t_sysrst;
    logic [15:0] b1, b2, b3, a;
    wr(3'd1, 16'h005A);
    wr(3'd4, 16'h0021);
    wr(3'd0, 16'h0004);
    rd(3'd2, b1); rd(3'd3, b2); rd(3'd1, b3);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd2, a); chk("R7 sec lo kept", a, b1);
    rd(3'd3, a); chk("R7 sec hi kept", a, b2);
    rd(3'd1, a); chk("R7 sub kept", a, b3);
    rd(3'd4, a); chk("R7 period kept", a, 16'h0021);
    rd(3'd0, a); chk("R7 ctrl kept", a, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1; osc_tick = 1'b1;
    t_por;
    t_busy;
    t_gate;
    t_cascade;
    t_rdy;
    t_alarm;
    t_sysrst;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule